// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a bank of 32-bit shadow registers that mirror a one-time-programmable fuse array, so that bus reads are served from flops rather than from the slow array. Each word carries two protection bits taken from the fuse array, a read lock and a write lock. A read of a read-locked word returns a fixed sentinel, and a write to a write-locked word is refused. Both raise a sticky error flag.

A reload sequencer refreshes the whole bank. Software starts it by writing the reload bit through the set alias of the control register. The sequencer walks the words in ascending order and waits a programmable strobe-plus-relax interval before capturing each one. It holds BUSY for the whole walk and clears the reload bit when it ends. Reset clears the bank and launches one reload by itself. While the error flag is up, the block refuses shadow reads, shadow writes and new reloads until software clears the flag through the clear alias. The fuse array is a behavioural model inside the block.

Top module: `fuse_shadow_bank`

## Requirements
- R1: Shadow word n is read at byte offset 0x400 + 0x10*n for n below NUM_WORDS. Read data appears on bus_rdata_o one clock after the request. A read of an address that is not in the map returns 0 and has no side effect. This covers offsets that are not 16-byte aligned, offsets below 0x400 and indices at or above NUM_WORDS.
- R2: The control register reads at offsets 0x000, 0x004 and 0x008. BUSY is bit 8, ERROR is bit 9 and RELOAD is bit 10. Writing bit 10 to the set alias 0x004 while ERROR is clear starts a reload. The reload copies every fuse word in ascending order and spends STROBE_CYC+RELAX_CYC cycles per word. BUSY stays high for exactly NUM_WORDS*(STROBE_CYC+RELAX_CYC) cycles, and RELOAD clears itself when the last word is captured.
- R3: A shadow write while BUSY is high sets ERROR and leaves the shadow word unchanged.
- R4: A shadow write to a write-locked word sets ERROR and leaves the word unchanged. A word is write-locked when n mod 16 = 6. A write to an unlocked word stores the data.
- R5: A read of a read-locked word returns 0xBADABADA and sets ERROR. A word is read-locked when n mod 16 = 11.
- R6: While ERROR is set, shadow reads return 0, shadow writes are ignored and a reload request is ignored. Writing bit 9 to the clear alias 0x008 clears ERROR.
- R7: Fuse word n holds 0xF5E00000 + n*0x00010101. A reload restores any shadow word that software has overwritten.
- R8: Reset clears all shadow words, ERROR and BUSY. An automatic reload then starts on the first clock after reset.
- R9: Writes to the plain control offset 0x000 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request and held until the next read |
| busy_o | output | 1 | Reload in progress (BUSY) |
| error_o | output | 1 | Sticky access error (ERROR) |

## Verification
The bench builds the block with 64 words and a three-cycle per-word interval (strobe 2, relax 1). With these values a full reload takes 192 cycles, so the bench can time BUSY exactly and can place a write inside a running reload, after word 0 is captured. The 64-word map reaches both lock patterns (words 6, 11 and 27), the last valid word and the first index past the end. All of the sticky-error paths are therefore exercised, along with the boundary of the decode.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int unsigned CTRL_BUSY_BIT   = 8;
  localparam int unsigned CTRL_ERR_BIT    = 9;
  localparam int unsigned CTRL_RELOAD_BIT = 10;
  localparam logic [31:0] LOCKED_SENTINEL = 32'hBADA_BADA;
  localparam int unsigned SHADOW_BASE     = 'h400;
  localparam int unsigned SHADOW_STEP_LG  = 4;
  localparam int unsigned CTRL_OFS        = 'h000;
  localparam int unsigned CTRL_SET_OFS    = 'h004;
  localparam int unsigned CTRL_CLR_OFS    = 'h008;

  typedef struct packed {
    logic [31:0] data;
    logic        rlock;
    logic        wlock;
  } fuse_entry_t;
endpackage

// File: rtl/fsb_fuse_model.sv
module fsb_fuse_model
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS),
  parameter logic [31:0] FUSE_BASE = 32'hF5E0_0000,
  parameter logic [31:0] FUSE_STEP = 32'h0001_0101,
  parameter logic [3:0]  RLOCK_SEL = 4'hB,
  parameter logic [3:0]  WLOCK_SEL = 4'h6
) (
  input  logic [IDX_W-1:0] idx_i,
  output fuse_entry_t      ent_o
);
  // behavioural array: content and lock pattern are a function of the index
  always_comb begin
    ent_o.data  = FUSE_BASE + (32'(idx_i) * FUSE_STEP);
    ent_o.rlock = (idx_i[3:0] == RLOCK_SEL);
    ent_o.wlock = (idx_i[3:0] == WLOCK_SEL);
  end
endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq #(
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned WAIT_CYC  = 6,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned CNT_W    = $clog2(WAIT_CYC) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_step;

  assign last_step = (cnt_q == CNT_W'(WAIT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cnt_q  <= '0;
      end
    end else if (last_step) begin
      cnt_q <= '0;
      if (idx_q == IDX_W'(NUM_WORDS - 1)) busy_q <= 1'b0;
      else                                 idx_q  <= idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign cap_o  = busy_q && last_step;
  assign done_o = cap_o && (idx_q == IDX_W'(NUM_WORDS - 1));

  p_idx_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (32'(idx_q) < NUM_WORDS));
  p_done_ends_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  p_idx_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !done_o) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/fsb_shadow_store.sv
module fsb_shadow_store
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  fuse_entry_t      cap_ent_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wr_data_i,
  output logic             wr_wlock_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o,
  output logic             rd_rlock_o
);
  logic [31:0] word_q  [NUM_WORDS];
  logic        rlock_q [NUM_WORDS];
  logic        wlock_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g]  <= '0;
        rlock_q[g] <= 1'b0;
        wlock_q[g] <= 1'b0;
      end else if (cap_en_i && (cap_idx_i == IDX_W'(g))) begin
        word_q[g]  <= cap_ent_i.data;
        rlock_q[g] <= cap_ent_i.rlock;
        wlock_q[g] <= cap_ent_i.wlock;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        word_q[g] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o  = '0;
    rd_rlock_o = 1'b0;
    wr_wlock_o = 1'b0;
    if (32'(rd_idx_i) < NUM_WORDS) begin
      rd_data_o  = word_q[rd_idx_i];
      rd_rlock_o = rlock_q[rd_idx_i];
    end
    if (32'(wr_idx_i) < NUM_WORDS) wr_wlock_o = wlock_q[wr_idx_i];
  end

  // the sequencer and the bus never update the store in the same cycle
  p_cap_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_en_i && wr_en_i));
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import fsb_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 64,
  parameter int unsigned STROBE_CYC = 4,
  parameter int unsigned RELAX_CYC  = 2,
  parameter int unsigned ADDR_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              busy_o,
  output logic              error_o
);
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS);
  localparam int unsigned WAIT_CYC = STROBE_CYC + RELAX_CYC;
  localparam int unsigned OFS_W    = ADDR_W - SHADOW_STEP_LG;

  logic              err_q, reload_q, rd_q;
  logic [31:0]       rdata_q;
  logic [ADDR_W-1:0] rel_addr;
  logic [OFS_W-1:0]  word_sel;
  logic              sh_hit, ctrl_hit, set_hit, clr_hit;
  logic              sh_rd, sh_wr;
  logic [IDX_W-1:0]  sh_idx;
  logic              seq_busy, seq_cap, seq_done;
  logic [IDX_W-1:0]  seq_idx;
  fuse_entry_t       fuse_ent;
  logic [31:0]       st_rdata;
  logic              st_rlock, st_wlock, st_wr_en;
  logic [31:0]       ctrl_val;

  // address decode
  assign rel_addr = bus_addr_i - ADDR_W'(SHADOW_BASE);
  assign word_sel = rel_addr[ADDR_W-1:SHADOW_STEP_LG];
  assign sh_hit   = (bus_addr_i >= ADDR_W'(SHADOW_BASE)) &&
                    (bus_addr_i[SHADOW_STEP_LG-1:0] == '0) &&
                    (word_sel < OFS_W'(NUM_WORDS));
  assign sh_idx   = word_sel[IDX_W-1:0];
  assign ctrl_hit = (bus_addr_i == ADDR_W'(CTRL_OFS));
  assign set_hit  = (bus_addr_i == ADDR_W'(CTRL_SET_OFS));
  assign clr_hit  = (bus_addr_i == ADDR_W'(CTRL_CLR_OFS));
  assign sh_rd    = bus_req_i && !bus_we_i && sh_hit;
  assign sh_wr    = bus_req_i &&  bus_we_i && sh_hit;

  fsb_fuse_model #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_fuse (
    .idx_i (seq_idx),
    .ent_o (fuse_ent)
  );

  fsb_reload_seq #(
    .NUM_WORDS (NUM_WORDS),
    .WAIT_CYC  (WAIT_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (reload_q && !err_q),
    .busy_o  (seq_busy),
    .cap_o   (seq_cap),
    .idx_o   (seq_idx),
    .done_o  (seq_done)
  );

  assign st_wr_en = sh_wr && !err_q && !seq_busy && !st_wlock;

  fsb_shadow_store #(
    .NUM_WORDS (NUM_WORDS)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (seq_cap),
    .cap_idx_i  (seq_idx),
    .cap_ent_i  (fuse_ent),
    .wr_en_i    (st_wr_en),
    .wr_idx_i   (sh_idx),
    .wr_data_i  (bus_wdata_i),
    .wr_wlock_o (st_wlock),
    .rd_idx_i   (sh_idx),
    .rd_data_o  (st_rdata),
    .rd_rlock_o (st_rlock)
  );

  // error flag and reload request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      reload_q <= 1'b1;   // one automatic reload after reset
    end else begin
      if (sh_rd && !err_q && st_rlock)                   err_q <= 1'b1;
      else if (sh_wr && !err_q && (seq_busy || st_wlock)) err_q <= 1'b1;
      else if (bus_req_i && bus_we_i && clr_hit && bus_wdata_i[CTRL_ERR_BIT])
        err_q <= 1'b0;
      if (seq_done) reload_q <= 1'b0;
      else if (bus_req_i && bus_we_i && set_hit && bus_wdata_i[CTRL_RELOAD_BIT] && !err_q)
        reload_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl_val                  = '0;
    ctrl_val[CTRL_BUSY_BIT]   = seq_busy;
    ctrl_val[CTRL_ERR_BIT]    = err_q;
    ctrl_val[CTRL_RELOAD_BIT] = reload_q;
  end

  // read data path, one cycle latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (bus_req_i && !bus_we_i) begin
      if (ctrl_hit || set_hit || clr_hit) rdata_q <= ctrl_val;
      else if (sh_hit) begin
        if (err_q)         rdata_q <= '0;
        else if (st_rlock) rdata_q <= LOCKED_SENTINEL;
        else               rdata_q <= st_rdata;
      end else             rdata_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= sh_rd;
  end

  assign bus_rdata_o = rdata_q;
  assign busy_o      = seq_busy;
  assign error_o     = err_q;

  p_busy_has_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |-> reload_q);
  p_start_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_busy) |-> !$past(err_q));
  p_wr_in_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_wr && seq_busy && !err_q) |=> err_q);
  p_wlock_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_wr && !seq_busy && !err_q && st_wlock) |=> err_q);
  p_sentinel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_rd && !err_q && st_rlock) |=> (rdata_q == LOCKED_SENTINEL && err_q && rd_q));
  p_refused_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_rd && err_q) |=> (rdata_q == '0));
endmodule

// File: tb/fuse_shadow_bank_tb.sv
module fuse_shadow_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 64;
  localparam int SC = 2;
  localparam int RC = 1;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  // R1, R4, R7, R9 table: reads check exp, writes ignore it
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0400, 32'h0,        32'hF5E0_0000},
    '{1'b0, 16'h0410, 32'h0,        32'hF5E1_0101},
    '{1'b0, 16'h07F0, 32'h0,        32'hF61F_3F3F},
    '{1'b1, 16'h0420, 32'h1234_5678, 32'h0},
    '{1'b0, 16'h0420, 32'h0,        32'h1234_5678},
    '{1'b0, 16'h0404, 32'h0,        32'h0},
    '{1'b0, 16'h040C, 32'h0,        32'h0},
    '{1'b0, 16'h0800, 32'h0,        32'h0},
    '{1'b1, 16'h0000, 32'h0000_0400, 32'h0},
    '{1'b0, 16'h0000, 32'h0,        32'h0},
    '{1'b1, 16'h0470, 32'hCAFE_F00D, 32'h0},
    '{1'b0, 16'h0470, 32'h0,        32'hCAFE_F00D},
    '{1'b0, 16'h03F0, 32'h0,        32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, err;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_shadow_bank #(
    .NUM_WORDS  (NW),
    .STROBE_CYC (SC),
    .RELAX_CYC  (RC),
    .ADDR_W     (16)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_req_i   (req),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .busy_o      (busy),
    .error_o     (err)
  );

  function automatic logic [31:0] fuse_val(int n);
    return 32'hF5E0_0000 + 32'(n) * 32'h0001_0101;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and leave at a falling edge
  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "busy in reset", 32'(busy), 32'd0);
    chk("R8", "error in reset", 32'(err), 32'd0);
    rst_n = 1'b1;
    bus_rd(16'h07F0, d);
    chk("R8", "shadow cleared by reset", d, 32'h0);
    bus_rd(16'h0000, d);
    chk("R8", "auto reload running", d, 32'h0000_0500);
    wait_idle();
    bus_rd(16'h0430, d);
    chk("R8", "auto reload filled word 3", d, fuse_val(3));

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) bus_wr(VECS[i].addr, VECS[i].wdata);
      else begin
        bus_rd(VECS[i].addr, d);
        chk("R1/R4/R7/R9", $sformatf("vector %0d", i), d, VECS[i].exp);
      end
    end
    chk("R9", "no reload from plain ctrl write", 32'(busy), 32'd0);
    chk("R1", "no error after table", 32'(err), 32'd0);

    // R2 reload timing and self clear
    bus_wr(16'h0004, 32'h0000_0400);
    n = 0;
    for (int g = 0; g < 10 && !busy; g++) @(negedge clk);
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk("R2", "busy cycles", 32'(n), 32'(NW * (SC + RC)));
    bus_rd(16'h0000, d);
    chk("R2", "reload bit self cleared", d, 32'h0);
    bus_rd(16'h0420, d);
    chk("R7", "reload restores word 2", d, fuse_val(2));
    bus_rd(16'h0470, d);
    chk("R7", "reload restores word 7", d, fuse_val(7));

    // R3 write during reload
    bus_wr(16'h0004, 32'h0000_0400);
    for (int g = 0; g < 10 && !busy; g++) @(negedge clk);
    repeat (10) @(negedge clk);
    bus_wr(16'h0400, 32'hDEAD_BEEF);
    chk("R3", "error after write in reload", 32'(err), 32'd1);
    wait_idle();
    bus_rd(16'h0000, d);
    chk("R3", "ctrl after reload with error", d, 32'h0000_0200);
    bus_wr(16'h0008, 32'h0000_0200);
    bus_rd(16'h0400, d);
    chk("R3", "word 0 unchanged", d, fuse_val(0));

    // R4 write-locked word
    bus_wr(16'h0460, 32'h0);
    chk("R4", "error after locked write", 32'(err), 32'd1);
    bus_wr(16'h0008, 32'h0000_0200);
    bus_rd(16'h0460, d);
    chk("R4", "word 6 unchanged", d, fuse_val(6));

    // R5 read-locked word, then R6 refusal while error
    bus_rd(16'h04B0, d);
    chk("R5", "sentinel word 11", d, 32'hBADA_BADA);
    chk("R5", "error after locked read", 32'(err), 32'd1);
    bus_rd(16'h0000, d);
    chk("R6", "ctrl readable with error", d, 32'h0000_0200);
    bus_rd(16'h0410, d);
    chk("R6", "read refused", d, 32'h0);
    bus_wr(16'h0420, 32'h5555_5555);
    bus_wr(16'h0004, 32'h0000_0400);
    repeat (5) @(negedge clk);
    chk("R6", "reload refused", 32'(busy), 32'd0);
    bus_rd(16'h0000, d);
    chk("R6", "reload bit not set", d, 32'h0000_0200);
    bus_wr(16'h0008, 32'h0000_0200);
    chk("R6", "error cleared", 32'(err), 32'd0);
    bus_rd(16'h0420, d);
    chk("R6", "write ignored under error", d, fuse_val(2));
    bus_rd(16'h05B0, d);
    chk("R5", "sentinel word 27", d, 32'hBADA_BADA);
    bus_wr(16'h0008, 32'h0000_0200);
    chk("R6", "error cleared again", 32'(err), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule